// File: doc/BRIEF.md
# Sprite Attribute Copy Engine

This block copies a fixed 160-byte table of sprite attributes from system memory into the sprite attribute memory. The CPU names a source page by writing one byte to a control register. From the next machine cycle on, the engine reads one byte per machine cycle from that page and writes it at the same offset above a fixed destination base. A write to the control register during a copy discards the copy in progress and starts again from offset zero.

While the copy runs, the engine also acts as the arbiter of the system bus for CPU accesses. In single-bus mode the CPU only keeps a small high RAM window. In dual-bus mode the CPU keeps every bus except the one the source page is on. The engine also changes what the display reader sees: sprite-scan reads return a hidden entry, and render-time fetches return the word pair being copied at that moment.

Top module: `sprite_dma`

## Requirements
- R1: A CPU write to address 0xFF46 in a cycle with `mcyc_en` high starts a copy. With mapped page P, offset k (0..159) is read from address P*256+k, in increasing order of k.
- R2: Offset k is written at address 0xFE00+k on the attribute port. The data written is the byte the read port returns in the same cycle.
- R3: Each copy writes exactly 160 bytes, one in each cycle with `mcyc_en` high, starting with the first such cycle after the start write. No write happens after the last byte.
- R4: `busy` is low after reset. It is high from the clock edge that takes the start write through the cycle of the final byte write, and it is low once that final write's edge has passed.
- R5: Page values 0xE0..0xFF are reduced by 0x20 before use (for example, 0xE3 reads from 0xC300). Values 0x00..0xDF are used unchanged.
- R6: A start write during a copy restarts the copy at offset 0 with the new page. The byte written in that same cycle still belongs to the old copy.
- R7: In single-bus mode (`dual_bus`=0) with `busy` high, only 0xFF80..0xFFFE and the control register are granted. A blocked read returns 0xFF on `cpu_rdata`, and a blocked write leaves `sys_we` low.
- R8: In dual-bus mode with `busy` high, addresses are classed into four buses: cartridge (0x0000..0x7FFF and 0xA000..0xBFFF), video (0x8000..0x9FFF), work (0xC000..0xFDFF) and internal (0xFE00..0xFFFF). A CPU access is granted exactly when its bus differs from the bus of the source page.
- R9: With `busy` low, every CPU access is granted, and reads pass `sys_rdata` through unchanged.
- R10: With `busy` high and `disp_scan` high, `disp_view` is 0xFFFF, which hides the entry. With `busy` low, `disp_view` equals `disp_oam_data`.
- R11: With `busy` high and `disp_scan` low, `disp_view` is {last byte written at an odd offset, last byte written at an even offset}, updated at each byte write's clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mcyc_en | input | 1 | Machine-cycle enable |
| dual_bus | input | 1 | 1: cartridge and work RAM are on separate buses |
| cpu_req | input | 1 | CPU access request |
| cpu_we | input | 1 | CPU access is a write |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data (page number on a start write) |
| cpu_grant | output | 1 | The access at `cpu_addr` is allowed this cycle |
| cpu_rdata | output | 8 | Read data to the CPU, 0xFF when blocked |
| sys_rdata | input | 8 | Memory read data for the CPU access |
| sys_re | output | 1 | Granted CPU read strobe to memory |
| sys_we | output | 1 | Granted CPU write strobe to memory |
| dma_rd_en | output | 1 | Engine read strobe |
| dma_rd_addr | output | 16 | Engine read address |
| dma_rd_data | input | 8 | Engine read data, same cycle |
| oam_we | output | 1 | Attribute memory write strobe |
| oam_waddr | output | 16 | Attribute memory write address |
| oam_wdata | output | 8 | Attribute memory write data |
| busy | output | 1 | A copy is in progress |
| disp_scan | input | 1 | 1: display is scanning sprites, 0: render fetch |
| disp_oam_data | input | 16 | Word the display read from attribute memory |
| disp_view | output | 16 | Word the display actually sees |

## Verification
The assertions check these properties on every cycle: the offset counter stays in range and steps by one, `busy` drops after the last byte, a start always re-arms offset zero, the folded page stays below 0xE0, blocked writes never reach memory, the high RAM window stays open, and the bus split and hidden scan entries hold in dual-bus mode. Some behaviour can only be shown by the bench's scenarios against its own memory model. This covers the exact address and data order of whole copies, page folding, the restart boundary with the old byte in flight, the byte pair shown to render fetches, and the 0xFF returned on blocked reads.

// File: rtl/sprite_dma_pkg.sv
package sprite_dma_pkg;

  typedef enum logic [1:0] {
    BUS_CART     = 2'd0,
    BUS_VIDEO    = 2'd1,
    BUS_WORK     = 2'd2,
    BUS_INTERNAL = 2'd3
  } bus_e;

  // Pages at or above 0xE0 fold back onto work RAM.
  function automatic logic [7:0] fold_page(input logic [7:0] p);
    return (p >= 8'hE0) ? (p - 8'h20) : p;
  endfunction

  // Which physical bus an address lives on.
  function automatic bus_e bus_of(input logic [15:0] a);
    if (a < 16'h8000)                      return BUS_CART;
    else if (a < 16'hA000)                 return BUS_VIDEO;
    else if (a < 16'hC000)                 return BUS_CART;
    else if (a < 16'hFE00)                 return BUS_WORK;
    else                                   return BUS_INTERNAL;
  endfunction

  function automatic logic in_window(input logic [15:0] a,
                                     input logic [15:0] lo,
                                     input logic [15:0] hi);
    return (a >= lo) && (a <= hi);
  endfunction

  // Source address of offset k within page p.
  function automatic logic [15:0] src_addr(input logic [7:0] p,
                                           input logic [7:0] k);
    return {p, 8'h00} + {8'h00, k};
  endfunction

endpackage

// File: rtl/sprite_dma_seq.sv
module sprite_dma_seq
  import sprite_dma_pkg::*;
#(
  parameter int XFER_LEN = 160,
  localparam int IDX_W = $clog2(XFER_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mcyc_en,
  input  logic             start,
  input  logic [7:0]       page_in,
  output logic             busy,
  output logic             step,
  output logic [IDX_W-1:0] idx,
  output logic [7:0]       page
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(XFER_LEN - 1);

  logic last_byte;

  assign step      = busy && mcyc_en;
  assign last_byte = (idx == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      idx  <= '0;
      page <= 8'h00;
    end else if (mcyc_en) begin
      if (start) begin
        busy <= 1'b1;
        idx  <= '0;
        page <= fold_page(page_in);
      end else if (busy) begin
        if (last_byte) begin
          busy <= 1'b0;
          idx  <= '0;
        end else begin
          idx <= idx + 1'b1;
        end
      end
    end
  end

  AST_START_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (mcyc_en && start) |=> (busy && idx == '0)); // R6

  AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (int'(idx) < XFER_LEN)); // R3

  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !start && !last_byte) |=> (idx == $past(idx) + 1'b1)); // R3

  AST_FINAL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !start && last_byte) |=> !busy); // R4

  AST_PAGE_FOLDED: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (page < 8'hE0)); // R5

endmodule

// File: rtl/sprite_dma_arb.sv
module sprite_dma_arb
  import sprite_dma_pkg::*;
#(
  parameter logic [15:0] CTRL_ADDR = 16'hFF46,
  parameter logic [15:0] HRAM_LO   = 16'hFF80,
  parameter logic [15:0] HRAM_HI   = 16'hFFFE
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        busy,
  input  logic        dual_bus,
  input  bus_e        src_bus,
  input  logic        cpu_req,
  input  logic        cpu_we,
  input  logic [15:0] cpu_addr,
  input  logic [7:0]  sys_rdata,
  output logic        cpu_grant,
  output logic [7:0]  cpu_rdata,
  output logic        sys_re,
  output logic        sys_we,
  output logic        ctrl_hit
);

  logic hram_hit;
  logic bus_clash;
  logic single_ok;
  logic dual_ok;

  assign ctrl_hit  = (cpu_addr == CTRL_ADDR);
  assign hram_hit  = in_window(cpu_addr, HRAM_LO, HRAM_HI);
  assign bus_clash = (bus_of(cpu_addr) == src_bus);
  assign single_ok = hram_hit || ctrl_hit;
  assign dual_ok   = !bus_clash || ctrl_hit;

  always_comb begin
    if (!busy)         cpu_grant = 1'b1;
    else if (dual_bus) cpu_grant = dual_ok;
    else               cpu_grant = single_ok;
  end

  assign cpu_rdata = cpu_grant ? sys_rdata : 8'hFF;
  assign sys_re    = cpu_req && !cpu_we && cpu_grant && !ctrl_hit;
  assign sys_we    = cpu_req &&  cpu_we && cpu_grant && !ctrl_hit;

  AST_DROP_BLOCKED_WR: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && cpu_we && !cpu_grant) |-> !sys_we); // R7

  AST_HRAM_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && in_window(cpu_addr, HRAM_LO, HRAM_HI)) |-> cpu_grant); // R7

  AST_IDLE_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && !busy) |-> cpu_grant); // R9

  AST_DUAL_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && dual_bus && cpu_req && (bus_of(cpu_addr) == src_bus)) |-> !cpu_grant); // R8

endmodule

// File: rtl/sprite_dma_view.sv
module sprite_dma_view #(
  parameter logic [15:0] HIDE_WORD = 16'hFFFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        wr_odd,
  input  logic [7:0]  wr_data,
  input  logic        busy,
  input  logic        disp_scan,
  input  logic [15:0] disp_oam_data,
  output logic [15:0] disp_view
);

  logic [7:0] lane_q [2];

  // Lane 0 holds the even-offset byte, lane 1 the odd-offset byte.
  for (genvar ln = 0; ln < 2; ln++) begin : g_lane
    logic lane_sel;
    assign lane_sel = wr_en && (wr_odd == ln[0]);
    always_ff @(posedge clk) begin
      if (!rst_n)        lane_q[ln] <= 8'h00;
      else if (lane_sel) lane_q[ln] <= wr_data;
    end
  end

  always_comb begin
    if (!busy)          disp_view = disp_oam_data;
    else if (disp_scan) disp_view = HIDE_WORD;
    else                disp_view = {lane_q[1], lane_q[0]};
  end

  AST_SCAN_HIDES: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && disp_scan) |-> (disp_view == HIDE_WORD)); // R10

endmodule

// File: rtl/sprite_dma.sv
module sprite_dma
  import sprite_dma_pkg::*;
#(
  parameter int          XFER_LEN  = 160,
  parameter logic [15:0] DST_BASE  = 16'hFE00,
  parameter logic [15:0] CTRL_ADDR = 16'hFF46,
  parameter logic [15:0] HRAM_LO   = 16'hFF80,
  parameter logic [15:0] HRAM_HI   = 16'hFFFE,
  parameter logic [15:0] HIDE_WORD = 16'hFFFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mcyc_en,
  input  logic        dual_bus,
  input  logic        cpu_req,
  input  logic        cpu_we,
  input  logic [15:0] cpu_addr,
  input  logic [7:0]  cpu_wdata,
  output logic        cpu_grant,
  output logic [7:0]  cpu_rdata,
  input  logic [7:0]  sys_rdata,
  output logic        sys_re,
  output logic        sys_we,
  output logic        dma_rd_en,
  output logic [15:0] dma_rd_addr,
  input  logic [7:0]  dma_rd_data,
  output logic        oam_we,
  output logic [15:0] oam_waddr,
  output logic [7:0]  oam_wdata,
  output logic        busy,
  input  logic        disp_scan,
  input  logic [15:0] disp_oam_data,
  output logic [15:0] disp_view
);

  localparam int IDX_W = $clog2(XFER_LEN);

  logic             ctrl_hit;
  logic             start;
  logic             step;
  logic [IDX_W-1:0] idx;
  logic [7:0]       page;
  logic [7:0]       idx8;
  bus_e             src_bus;

  assign start   = cpu_req && cpu_we && ctrl_hit && mcyc_en;
  assign idx8    = 8'(idx);
  assign src_bus = bus_of({page, 8'h00});

  sprite_dma_seq #(
    .XFER_LEN (XFER_LEN)
  ) seq_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .mcyc_en (mcyc_en),
    .start   (start),
    .page_in (cpu_wdata),
    .busy    (busy),
    .step    (step),
    .idx     (idx),
    .page    (page)
  );

  sprite_dma_arb #(
    .CTRL_ADDR (CTRL_ADDR),
    .HRAM_LO   (HRAM_LO),
    .HRAM_HI   (HRAM_HI)
  ) arb_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .dual_bus  (dual_bus),
    .src_bus   (src_bus),
    .cpu_req   (cpu_req),
    .cpu_we    (cpu_we),
    .cpu_addr  (cpu_addr),
    .sys_rdata (sys_rdata),
    .cpu_grant (cpu_grant),
    .cpu_rdata (cpu_rdata),
    .sys_re    (sys_re),
    .sys_we    (sys_we),
    .ctrl_hit  (ctrl_hit)
  );

  assign dma_rd_en   = step;
  assign dma_rd_addr = src_addr(page, idx8);
  assign oam_we      = step;
  assign oam_waddr   = DST_BASE + {8'h00, idx8};
  assign oam_wdata   = dma_rd_data;

  sprite_dma_view #(
    .HIDE_WORD (HIDE_WORD)
  ) view_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (step),
    .wr_odd        (idx8[0]),
    .wr_data       (dma_rd_data),
    .busy          (busy),
    .disp_scan     (disp_scan),
    .disp_oam_data (disp_oam_data),
    .disp_view     (disp_view)
  );

  AST_WRITE_ON_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    oam_we |-> (mcyc_en && busy)); // R3

endmodule

// File: tb/sprite_dma_tb_top.sv
module sprite_dma_tb_top;

  localparam int          LEN  = 160;
  localparam logic [15:0] CTRL = 16'hFF46;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mcyc_en;
  logic        dual_bus = 1'b0;
  logic        cpu_req = 1'b0;
  logic        cpu_we = 1'b0;
  logic [15:0] cpu_addr = 16'h0000;
  logic [7:0]  cpu_wdata = 8'h00;
  logic        cpu_grant;
  logic [7:0]  cpu_rdata;
  logic [7:0]  sys_rdata;
  logic        sys_re, sys_we;
  logic        dma_rd_en;
  logic [15:0] dma_rd_addr;
  logic [7:0]  dma_rd_data;
  logic        oam_we;
  logic [15:0] oam_waddr;
  logic [7:0]  oam_wdata;
  logic        busy;
  logic        disp_scan = 1'b0;
  logic [15:0] disp_oam_data = 16'h1234;
  logic [15:0] disp_view;

  int n_vec = 0;
  int n_bad = 0;
  int n_wr  = 0;
  logic [1:0] mcnt = 2'd0;
  logic [31:0] exp_q[$];   // {source address, destination address}
  logic [7:0] m_even = 8'h00;
  logic [7:0] m_odd  = 8'h00;

  always #2 clk = ~clk;    // 250 MHz

  always @(posedge clk) mcnt <= mcnt + 2'd1;
  assign mcyc_en = (mcnt == 2'd3);

  function automatic logic [7:0] mem_val(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction

  assign sys_rdata   = mem_val(cpu_addr);
  assign dma_rd_data = mem_val(dma_rd_addr);

  sprite_dma dut_i (
    .clk(clk), .rst_n(rst_n), .mcyc_en(mcyc_en), .dual_bus(dual_bus),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_grant(cpu_grant), .cpu_rdata(cpu_rdata), .sys_rdata(sys_rdata),
    .sys_re(sys_re), .sys_we(sys_we), .dma_rd_en(dma_rd_en), .dma_rd_addr(dma_rd_addr),
    .dma_rd_data(dma_rd_data), .oam_we(oam_we), .oam_waddr(oam_waddr), .oam_wdata(oam_wdata),
    .busy(busy), .disp_scan(disp_scan), .disp_oam_data(disp_oam_data), .disp_view(disp_view)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Driver: pushes the expected write sequence, then issues the start write.
  task automatic start_xfer(input logic [7:0] pg, input bit flush);
    logic [7:0] mp;
    @(negedge clk);
    while (!mcyc_en) @(negedge clk);
    #1;
    if (flush) exp_q.delete();
    mp = (pg >= 8'hE0) ? pg - 8'h20 : pg;
    for (int k = 0; k < LEN; k++)
      exp_q.push_back({{mp, 8'h00} + 16'(k), 16'hFE00 + 16'(k)});
    cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = CTRL; cpu_wdata = pg;
    @(negedge clk);
    cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = 16'h0000;
    chk(busy === 1'b1, "R4 busy after start", 32'(busy), 1);
  endtask

  task automatic probe(input logic [15:0] a, input bit we, input bit exp_g,
                       input string req);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a;
    #1;
    chk(cpu_grant === exp_g, req, 32'(cpu_grant), 32'(exp_g));
    if (!we)
      chk(cpu_rdata === (exp_g ? mem_val(a) : 8'hFF), {req, " rdata"},
          32'(cpu_rdata), 32'(exp_g ? mem_val(a) : 8'hFF));
    else
      chk(sys_we === exp_g, {req, " sys_we"}, 32'(sys_we), 32'(exp_g));
    cpu_req = 1'b0; cpu_we = 1'b0;
  endtask

  task automatic wait_done();
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
    chk(busy === 1'b0, "R4 busy low after last byte", 32'(busy), 0);
  endtask

  // Monitor: pops and compares each attribute write.
  always @(negedge clk) begin
    if (rst_n) begin
      if (busy && !disp_scan)
        chk(disp_view === {m_odd, m_even}, "R11 render view", 32'(disp_view),
            32'({m_odd, m_even}));
      if (oam_we) begin
        n_wr++;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R3 unexpected write", 32'(oam_waddr), 0);
        end else begin
          logic [31:0] it;
          it = exp_q.pop_front();
          chk(dma_rd_addr === it[31:16], "R1 source address", 32'(dma_rd_addr),
              32'(it[31:16]));
          chk(oam_waddr === it[15:0], "R2 destination address", 32'(oam_waddr),
              32'(it[15:0]));
          chk(oam_wdata === mem_val(it[31:16]), "R2 write data", 32'(oam_wdata),
              32'(mem_val(it[31:16])));
          if (it[0]) m_odd = mem_val(it[31:16]);
          else       m_even = mem_val(it[31:16]);
        end
      end
    end
  end

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    int w0;
    repeat (6) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy === 1'b0, "R4 reset busy", 32'(busy), 0);
    chk(oam_we === 1'b0, "R3 reset no write", 32'(oam_we), 0);
    probe(16'h1234, 1'b0, 1'b1, "R9 idle read");
    probe(16'hC010, 1'b1, 1'b1, "R9 idle write");

    // Single-bus copy from page 0x12.
    start_xfer(8'h12, 1'b0);
    probe(16'h1234, 1'b0, 1'b0, "R7 blocked cart read");
    probe(16'hFF80, 1'b0, 1'b1, "R7 hram low edge");
    probe(16'hFFFE, 1'b0, 1'b1, "R7 hram high edge");
    probe(16'hFFFF, 1'b0, 1'b0, "R7 above hram");
    probe(16'hC000, 1'b1, 1'b0, "R7 blocked write");
    @(negedge clk); disp_scan = 1'b1; #1;
    chk(disp_view === 16'hFFFF, "R10 scan hidden", 32'(disp_view), 32'hFFFF);
    disp_scan = 1'b0;
    wait_done();
    chk(n_wr == LEN, "R3 write count", 32'(n_wr), LEN);
    repeat (12) @(negedge clk);
    chk(n_wr == LEN, "R3 no extra writes", 32'(n_wr), LEN);
    disp_scan = 1'b1; #1;
    chk(disp_view === disp_oam_data, "R10 idle passthrough", 32'(disp_view),
        32'(disp_oam_data));
    disp_scan = 1'b0;

    // Dual-bus, work RAM source.
    dual_bus = 1'b1;
    start_xfer(8'hC1, 1'b0);
    probe(16'h4000, 1'b0, 1'b1, "R8 cart open");
    probe(16'h8800, 1'b0, 1'b1, "R8 video open");
    probe(16'hC500, 1'b0, 1'b0, "R8 work blocked");
    probe(16'hE100, 1'b1, 1'b0, "R8 echo blocked");
    wait_done();

    // Dual-bus, cartridge source.
    start_xfer(8'h05, 1'b0);
    probe(16'hA000, 1'b0, 1'b0, "R8 sram blocked");
    probe(16'h7FFF, 1'b0, 1'b0, "R8 rom blocked");
    probe(16'hD000, 1'b1, 1'b1, "R8 work open");
    wait_done();
    dual_bus = 1'b0;

    // Folded page.
    start_xfer(8'hE3, 1'b0);
    wait_done();
    start_xfer(8'hFF, 1'b0);
    wait_done();

    // Restart mid-copy.
    w0 = n_wr;
    start_xfer(8'h20, 1'b0);
    while (n_wr - w0 < 50) @(negedge clk);
    start_xfer(8'h30, 1'b1);
    wait_done();
    chk(n_wr - w0 == 51 + LEN, "R6 restart write count", 32'(n_wr - w0),
        32'(51 + LEN));

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule